// File: doc/BRIEF.md
# Adaptive Half-Bridge Dead-Time Controller

This block turns a single pulse-width command into two gate-drive enables for a half-bridge: one for the high-side switch and one for the low-side switch. It never lets both enables be high together. Each side is allowed to turn on only after a digital comparator flag reports that the opposite switch is really off, followed by a short settling delay. Dead time therefore follows the actual switching speed of the power stage instead of a fixed worst-case figure.

The command, the active-low low-side enable and the two comparator flags (low gate discharged, switch node low) each pass through a synchroniser before the sequencer uses them. Once the low-side enable is on, it stays on until the next rising command, so ringing on the switch node cannot chop it. If the switch node never reports low, a timeout turns the low side on anyway. Pulling the low-side enable input low shuts the low side off and leaves the high side alone. Either undervoltage flag forces both enables low. All delays are counted in clock cycles and set by parameters.

Top module: `hbridge_deadtime`

## Requirements
- R1: While reset is held and on the first cycles after it, both `hiDrive` and `loDrive` are 0. After reset the sequencer resynchronises on the current `pwmIn` level, and any low-side turn-on goes through the switch-node check or the timeout.
- R2: `hiDrive` and `loDrive` are never 1 in the same cycle.
- R3: After `pwmIn` rises, `loDrive` goes to 0 first. `hiDrive` stays 0 for as long as `lowGateOff` stays 0. It rises between SETTLE_CYCLES+1 and SETTLE_CYCLES+6 cycles after `lowGateOff` becomes 1, and never fewer than SETTLE_CYCLES cycles after `loDrive` fell.
- R4: After `pwmIn` falls, `hiDrive` goes to 0 within 5 cycles. `loDrive` stays 0 until `swNodeLow` is 1, then rises between SETTLE_CYCLES+1 and SETTLE_CYCLES+6 cycles after `swNodeLow` went to 1.
- R5: Once `loDrive` is 1, it stays 1 until `pwmIn` rises, `lowEnN` goes low, or an undervoltage flag is raised. Toggling `swNodeLow` has no effect on it.
- R6: If `swNodeLow` stays 0 after `pwmIn` falls, `loDrive` is forced to 1 between TIMEOUT_CYCLES and TIMEOUT_CYCLES+6 cycles later. This forced turn-on does not happen while `lowEnN` is 0.
- R7: `lowEnN` = 0 clears `loDrive` within SYNC_STAGES+2 cycles in any state, and keeps it cleared while `lowEnN` stays 0. `hiDrive` is not affected.
- R8: In steady state, (`lowEnN`, `pwmIn`) maps to (`loDrive`, `hiDrive`) as follows: (0,0)→(0,0), (0,1)→(0,1), (1,0)→(1,0), (1,1)→(0,1). This assumes the comparator flags follow the power stage.
- R9: `uvLow` = 1 or `uvHigh` = 1 drives both enables to 0 on the next clock edge and holds them there until both flags are 0. After that the sequence resumes on the current `pwmIn` level.
- R10: A `pwmIn` pulse that ends before `hiDrive` has turned on aborts the turn-on. `hiDrive` never rises, and the low side returns through the switch-node check or the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | Pulse-width command, 1 requests the high side |
| lowEnN | input | 1 | Low-side enable, active low: 0 disables the low side |
| lowGateOff | input | 1 | Comparator flag, 1 when the low-side gate has discharged |
| swNodeLow | input | 1 | Comparator flag, 1 when the switch node has fallen |
| uvLow | input | 1 | Undervoltage flag for the low-side supply, 1 = fault |
| uvHigh | input | 1 | Undervoltage flag for the high-side supply, 1 = fault |
| hiDrive | output | 1 | High-side gate enable |
| loDrive | output | 1 | Low-side gate enable |

## Verification
Three controls can land on the same edge: the command change that moves the sequencer, the low-side disable that masks `loDrive`, and an undervoltage flag that clears both enables. Directed cases raise the undervoltage flag while a rising command is waiting for the gate-off flag. They pull the disable low while the high side conducts, and end a command pulse in the middle of the settling count. The results are judged at the pins: `hiDrive` must stay unchanged under the disable, both enables must stay low during the fault, and no cycle may show both enables high. Seeded random segments then mix all three controls against a bench power-stage model. After each long, stable segment the pins are compared with the steady-state table.

// File: rtl/hbridge_deadtime_pkg.sv
package hbridge_deadtime_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HI_WAIT,
    PH_HI_SETTLE,
    PH_HI_ON,
    PH_LO_WAIT,
    PH_LO_SETTLE,
    PH_LO_ON
  } phase_t;

  typedef struct packed {
    logic hiOn;
    logic loOn;
    logic settleRun;
    logic timeoutRun;
  } strobe_t;

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= dIn;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], dIn};
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/hbdt_ctrl.sv
module hbdt_ctrl
  import hbridge_deadtime_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwmS,
  input  logic    lowEnS,
  input  logic    gateOffS,
  input  logic    swLowS,
  input  logic    uvAny,
  input  logic    settleDone,
  input  logic    timeoutDone,
  output strobe_t strb
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (uvAny) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:      phaseNext = pwmS ? PH_HI_WAIT : PH_LO_WAIT;
        PH_HI_WAIT: begin
          if (!pwmS)         phaseNext = PH_LO_WAIT;
          else if (gateOffS) phaseNext = PH_HI_SETTLE;
        end
        PH_HI_SETTLE: begin
          if (!pwmS)           phaseNext = PH_LO_WAIT;
          else if (settleDone) phaseNext = PH_HI_ON;
        end
        PH_HI_ON:     if (!pwmS) phaseNext = PH_LO_WAIT;
        PH_LO_WAIT: begin
          if (pwmS)                       phaseNext = PH_HI_WAIT;
          else if (swLowS)                phaseNext = PH_LO_SETTLE;
          else if (timeoutDone && lowEnS) phaseNext = PH_LO_ON;
        end
        PH_LO_SETTLE: begin
          if (pwmS)            phaseNext = PH_HI_WAIT;
          else if (settleDone) phaseNext = PH_LO_ON;
        end
        PH_LO_ON:     if (pwmS) phaseNext = PH_HI_WAIT;
        default:      phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.hiOn       = (phase == PH_HI_ON);
    strb.loOn       = (phase == PH_LO_ON);
    strb.settleRun  = (phase == PH_HI_SETTLE) || (phase == PH_LO_SETTLE);
    strb.timeoutRun = (phase == PH_LO_WAIT);
  end

endmodule

// File: rtl/hbdt_datapath.sv
module hbdt_datapath
  import hbridge_deadtime_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 31
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    lowEnS,
  input  logic    uvAny,
  output logic    settleDone,
  output logic    timeoutDone,
  output logic    hiDrive,
  output logic    loDrive
);

  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES + 1);

  logic [SET_W-1:0] settleCnt;
  logic [TO_W-1:0]  timeoutCnt;

  assign settleDone  = (settleCnt == SET_W'(SETTLE_CYCLES - 1));
  assign timeoutDone = (timeoutCnt == TO_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               settleCnt <= '0;
    else if (!strb.settleRun) settleCnt <= '0;
    else if (!settleDone)    settleCnt <= settleCnt + SET_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timeoutCnt <= '0;
    else if (!strb.timeoutRun) timeoutCnt <= '0;
    else if (!timeoutDone)     timeoutCnt <= timeoutCnt + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiDrive <= 1'b0;
      loDrive <= 1'b0;
    end else begin
      hiDrive <= strb.hiOn && !uvAny;
      loDrive <= strb.loOn && lowEnS && !uvAny;
    end
  end

endmodule

// File: rtl/hbridge_deadtime.sv
module hbridge_deadtime
  import hbridge_deadtime_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int SETTLE_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 31
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic lowEnN,
  input  logic lowGateOff,
  input  logic swNodeLow,
  input  logic uvLow,
  input  logic uvHigh,
  output logic hiDrive,
  output logic loDrive
);

  localparam int SENSE_W = 4;

  logic [SENSE_W-1:0] senseRaw, senseSync;
  strobe_t strb;
  logic    settleDone, timeoutDone;
  logic    uvAny;

  assign senseRaw = {pwmIn, lowEnN, lowGateOff, swNodeLow};
  assign uvAny    = uvLow | uvHigh;

  hbdt_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (senseRaw),
    .dOut (senseSync)
  );

  hbdt_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pwmS        (senseSync[3]),
    .lowEnS      (senseSync[2]),
    .gateOffS    (senseSync[1]),
    .swLowS      (senseSync[0]),
    .uvAny       (uvAny),
    .settleDone  (settleDone),
    .timeoutDone (timeoutDone),
    .strb        (strb)
  );

  hbdt_datapath #(
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lowEnS      (senseSync[2]),
    .uvAny       (uvAny),
    .settleDone  (settleDone),
    .timeoutDone (timeoutDone),
    .hiDrive     (hiDrive),
    .loDrive     (loDrive)
  );

endmodule

// File: rtl/hbridge_deadtime_chk.sv
module hbridge_deadtime_chk #(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic pwmIn,
  input logic lowEnN,
  input logic uvLow,
  input logic uvHigh,
  input logic hiDrive,
  input logic loDrive
);

  logic [15:0] loOffCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              loOffCnt <= '0;
    else if (loDrive)       loOffCnt <= '0;
    else if (loOffCnt != '1) loOffCnt <= loOffCnt + 16'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hiDrive && loDrive)); // R2

  AST_UV_BOTH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (uvLow || uvHigh) |=> (!hiDrive && !loDrive)); // R9

  AST_LOW_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lowEnN, SYNC_STAGES + 1) |-> !loDrive); // R7

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiDrive) |-> (loOffCnt >= 16'(SETTLE_CYCLES))); // R3

  AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loDrive) |-> ($past(pwmIn, SYNC_STAGES + 2) || !$past(lowEnN, SYNC_STAGES + 1)
                        || $past(uvLow) || $past(uvHigh))); // R5

endmodule

bind hbridge_deadtime hbridge_deadtime_chk #(
  .SYNC_STAGES   (SYNC_STAGES),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pwmIn   (pwmIn),
  .lowEnN  (lowEnN),
  .uvLow   (uvLow),
  .uvHigh  (uvHigh),
  .hiDrive (hiDrive),
  .loDrive (loDrive)
);

// File: tb/hbridge_deadtime_bench.sv
module hbridge_deadtime_bench;

  localparam int SYNC    = 2;
  localparam int SETTLE  = 4;
  localparam int TIMEOUT = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0;
  logic lowEnN = 1'b1;
  logic lowGateOff = 1'b0;
  logic swNodeLow = 1'b0;
  logic uvLow = 1'b0;
  logic uvHigh = 1'b0;
  logic hiDrive, loDrive;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit plantOn = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hbridge_deadtime #(
    .SYNC_STAGES    (SYNC),
    .SETTLE_CYCLES  (SETTLE),
    .TIMEOUT_CYCLES (TIMEOUT)
  ) u_hbridge_deadtime (
    .clk        (clk),
    .rstN       (rstN),
    .pwmIn      (pwmIn),
    .lowEnN     (lowEnN),
    .lowGateOff (lowGateOff),
    .swNodeLow  (swNodeLow),
    .uvLow      (uvLow),
    .uvHigh     (uvHigh),
    .hiDrive    (hiDrive),
    .loDrive    (loDrive)
  );

  function automatic logic expLo(logic en, logic pwm);
    return en && !pwm;
  endfunction

  function automatic logic expHi(logic en, logic pwm);
    return (en || !en) && pwm;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (plantOn) begin
        lowGateOff = !loDrive;
        swNodeLow  = !hiDrive;
      end
    end
  endtask

  task automatic waitLo(input logic val, input int maxCyc, output int cyc);
    cyc = 0;
    while (loDrive !== val && cyc < maxCyc) begin
      step(1);
      cyc++;
    end
  endtask

  task automatic waitHi(input logic val, input int maxCyc, output int cyc);
    cyc = 0;
    while (hiDrive !== val && cyc < maxCyc) begin
      step(1);
      cyc++;
    end
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt == 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCnt, 0);
      finish();
    end
  end

  initial begin
    int cyc;
    int drops;
    int hiRise;
    int loFell;
    int seedDummy;
    seedDummy = $urandom(32'h5eed_0042);

    // R1: reset state
    step(5);
    chk(hiDrive == 1'b0 && loDrive == 1'b0, "R1 reset outputs low", {hiDrive, loDrive}, 0);
    rstN = 1'b1;
    step(2);
    chk(hiDrive == 1'b0 && loDrive == 1'b0, "R1 after reset outputs low", {hiDrive, loDrive}, 0);

    // R6: timeout forces the low side on when the switch-node flag never arrives
    waitLo(1'b1, TIMEOUT + 20, cyc);
    chk(loDrive == 1'b1 && cyc >= TIMEOUT - 2 && cyc <= TIMEOUT + 6, "R6 timeout turn-on", cyc, TIMEOUT + 2);
    chk(hiDrive == 1'b0, "R6 high side stays off", hiDrive, 0);

    // R5: latched low side ignores switch-node ringing
    drops = 0;
    for (int i = 0; i < 16; i++) begin
      swNodeLow = i[0];
      step(1);
      if (loDrive !== 1'b1) drops++;
    end
    chk(drops == 0, "R5 low side held through ringing", drops, 0);

    // R3: rising command, high side waits for the gate-off flag
    swNodeLow = 1'b0;
    lowGateOff = 1'b0;
    pwmIn = 1'b1;
    step(6);
    chk(loDrive == 1'b0, "R3 low side turns off first", loDrive, 0);
    step(20);
    chk(hiDrive == 1'b0, "R3 high side waits for gate-off flag", hiDrive, 0);
    lowGateOff = 1'b1;
    waitHi(1'b1, SETTLE + 20, cyc);
    chk(hiDrive == 1'b1 && cyc >= SETTLE + 1 && cyc <= SETTLE + 6, "R3 settle delay", cyc, SETTLE + 4);

    // R4: falling command, low side waits for switch-node flag
    lowGateOff = 1'b0;
    pwmIn = 1'b0;
    waitHi(1'b0, 10, cyc);
    chk(hiDrive == 1'b0 && cyc <= 5, "R4 high side off", cyc, 4);
    chk(loDrive == 1'b0, "R4 low side waits", loDrive, 0);
    step(5);
    chk(loDrive == 1'b0, "R4 low side still waits", loDrive, 0);
    swNodeLow = 1'b1;
    waitLo(1'b1, SETTLE + 20, cyc);
    chk(loDrive == 1'b1 && cyc >= SETTLE + 1 && cyc <= SETTLE + 6, "R4 switch-node turn-on", cyc, SETTLE + 4);

    // R7: disable clears low side
    lowEnN = 1'b0;
    step(SYNC + 2);
    chk(loDrive == 1'b0, "R7 disable clears low side", loDrive, 0);
    step(10);
    chk(loDrive == 1'b0 && hiDrive == 1'b0, "R7 low side stays cleared", {hiDrive, loDrive}, 0);

    // R8: (0,1) -> (0,1)
    lowGateOff = 1'b1;
    pwmIn = 1'b1;
    waitHi(1'b1, 30, cyc);
    chk(hiDrive == 1'b1 && loDrive == 1'b0, "R8 disabled, command high", {hiDrive, loDrive}, 2);

    // R6/R8: no forced turn-on while disabled, (0,0) -> (0,0)
    lowGateOff = 1'b0;
    swNodeLow = 1'b0;
    pwmIn = 1'b0;
    step(TIMEOUT + 15);
    chk(loDrive == 1'b0 && hiDrive == 1'b0, "R6 no forced turn-on while disabled", {hiDrive, loDrive}, 0);

    // R8: (1,0) -> (1,0)
    lowEnN = 1'b1;
    waitLo(1'b1, 10, cyc);
    chk(loDrive == 1'b1 && hiDrive == 1'b0, "R8 enabled, command low", {hiDrive, loDrive}, 1);

    // R9: undervoltage with a rising command waiting for the gate-off flag
    pwmIn = 1'b1;
    step(2);
    uvHigh = 1'b1;
    step(1);
    chk(hiDrive == 1'b0 && loDrive == 1'b0, "R9 undervoltage clears both", {hiDrive, loDrive}, 0);
    lowGateOff = 1'b1;
    drops = 0;
    for (int i = 0; i < 15; i++) begin
      step(1);
      if (hiDrive || loDrive) drops++;
    end
    chk(drops == 0, "R9 both held low during fault", drops, 0);
    uvHigh = 1'b0;
    waitHi(1'b1, 30, cyc);
    chk(hiDrive == 1'b1, "R9 resumes after fault", hiDrive, 1);

    // R7: high side unaffected by disable
    lowEnN = 1'b0;
    drops = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (hiDrive !== 1'b1) drops++;
    end
    chk(drops == 0, "R7 high side unaffected by disable", drops, 0);
    lowEnN = 1'b1;
    step(4);
    uvLow = 1'b1;
    step(1);
    chk(hiDrive == 1'b0 && loDrive == 1'b0, "R9 low-supply fault clears high side", {hiDrive, loDrive}, 0);
    uvLow = 1'b0;

    pwmIn = 1'b0;
    lowGateOff = 1'b0;
    swNodeLow = 1'b1;
    waitLo(1'b1, 40, cyc);
    chk(loDrive == 1'b1, "R4 low side back on", loDrive, 1);

    // R10: short pulse while waiting for gate-off flag
    swNodeLow = 1'b0;
    pwmIn = 1'b1;
    step(3);
    pwmIn = 1'b0;
    hiRise = 0;
    loFell = 0;
    for (int i = 0; i < TIMEOUT + 20; i++) begin
      step(1);
      if (hiDrive) hiRise++;
      if (!loDrive) loFell = 1;
    end
    chk(hiRise == 0, "R10 aborted pulse keeps high side off", hiRise, 0);
    chk(loFell == 1 && loDrive == 1'b1, "R10 low side returns via timeout", loDrive, 1);

    // R10: short pulse aborted in the middle of the settle count
    lowGateOff = 1'b1;
    pwmIn = 1'b1;
    step(3);
    pwmIn = 1'b0;
    swNodeLow = 1'b1;
    hiRise = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (hiDrive) hiRise++;
    end
    chk(hiRise == 0, "R10 abort during settle", hiRise, 0);
    chk(loDrive == 1'b1, "R10 low side returns via switch node", loDrive, 1);

    // Random segments against a power-stage model
    plantOn = 1'b1;
    for (int seg = 0; seg < 80; seg++) begin
      int len;
      int overlap;
      logic segPwm;
      logic segEn;
      bit segUv;
      segPwm = 1'($urandom % 2);
      segEn  = 1'(($urandom % 4) != 0);
      segUv  = (($urandom % 7) == 0);
      len    = 8 + int'($urandom % 70);
      pwmIn  = segPwm;
      lowEnN = segEn;
      if (segUv) begin
        if ($urandom % 2) uvLow = 1'b1;
        else              uvHigh = 1'b1;
      end
      overlap = 0;
      for (int c = 0; c < len; c++) begin
        step(1);
        if (c == 3) begin
          uvLow = 1'b0;
          uvHigh = 1'b0;
        end
        if (hiDrive && loDrive) overlap++;
      end
      chk(overlap == 0, "R2 no overlap", overlap, 0);
      if (len >= 55) begin
        chk(loDrive == expLo(segEn, segPwm) && hiDrive == expHi(segEn, segPwm),
            "R8 steady-state table", {hiDrive, loDrive},
            {expHi(segEn, segPwm), expLo(segEn, segPwm)});
      end
    end

    finish();
  end

endmodule